// File: doc/BRIEF.md
# Two-Way Page Translation Buffer

This block keeps recently used virtual-to-physical page mappings close to the core. It handles a 64-bit virtual address with 16 KB pages. The low 14 bits are the page offset and pass through unchanged. The 50 bits above them form the virtual page number. The lowest bits of that page number pick a set, and the remaining upper bits form the stored tag. Each set holds two ways. Every entry keeps:

- a physical page number, sized for a 40-bit physical address;
- a valid flag;
- a recency flag;
- a written flag;
- three access-permission bits.

A lookup is presented for one cycle with an access kind. One cycle later the block reports exactly one outcome: a hit with the physical address, a permission fault, or a miss. A miss tells the surrounding logic to start a table walk. The walker then installs the mapping through the refill port. The block picks the way to replace from the valid and recency flags. A flush input empties the whole buffer in one cycle.

Top module: `xlat_buffer`

## Requirements
- R1: While `rst_n` is low and after its release, the buffer holds no valid entry and every lookup output is 0. The first lookup after reset reports a miss.
- R2: A lookup presented with `lk_valid_i` high produces its result in the next cycle. In that cycle `lk_done_o` is 1 and exactly one of `lk_hit_o`, `lk_fault_o` and `lk_miss_o` is 1. In a cycle with no lookup, all four are 0.
- R3: On a hit, `lk_pa_o` equals the stored physical page number concatenated above `lk_va_i[13:0]`. When there is no hit, `lk_pa_o` is 0.
- R4: The set index is `lk_va_i[14 +: IDX_W]` and the tag is the bits above it. A lookup misses unless a valid way in the indexed set holds an equal tag. `fill_vpn_i` is the page number, which equals the address shifted right by 14.
- R5: The permission bits are bit0 read, bit1 write and bit2 execute. Access codes are 0 load, 1 store and 2 fetch; code 3 is treated as a load. A tag match without the needed bit gives `lk_fault_o=1` and `lk_hit_o=0`.
- R6: A store hit marks the entry as written. `lk_dirty_o` is 1 only with a hit, and it shows the entry's written flag including this access. A faulting store leaves the flag clear. A refill clears the flag.
- R7: A refill goes to an invalid way when the set has one, preferring way 0. The two ways of a set can hold two mappings at the same time.
- R8: A tag match or a refill sets that way's recency flag and clears the other way's flag. When both ways are valid, a refill replaces the way whose flag is clear.
- R9: A refill whose page number is already present overwrites that same way. It never creates a second copy, and the other way keeps its mapping.
- R10: A flush invalidates every entry before the next cycle. A refill presented in the same cycle as a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Invalidate every entry |
| lk_valid_i | input | 1 | Lookup request this cycle |
| lk_va_i | input | VA_W | Virtual address to translate |
| lk_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| fill_valid_i | input | 1 | Install a mapping this cycle |
| fill_vpn_i | input | VA_W-OFF_W | Virtual page number being installed |
| fill_ppn_i | input | PA_W-OFF_W | Physical page number being installed |
| fill_rights_i | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Translation found and permitted |
| lk_miss_o | output | 1 | No valid mapping: walk needed |
| lk_fault_o | output | 1 | Mapping found but access not permitted |
| lk_pa_o | output | PA_W | Translated physical address |
| lk_dirty_o | output | 1 | Written flag of the hit entry |

## Verification
The bench builds the block with `IDX_W=2` and keeps the default address widths. With only four sets, a few chosen tags are enough to force set conflicts, so filling both ways, evicting by recency and overwriting a present page all happen within a handful of refills. The full 64-bit address and 48-bit tag are kept, so upper tag bits that differ in only a few positions are still compared. The offset pass-through is checked with non-zero offsets.

// File: rtl/xlat_pkg.sv
// Shared encodings for the translation buffer: access kinds and the
// positions of the permission bits. Assumes a 2-bit access code.
package xlat_pkg;
    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam int RIGHT_RD = 0;
    localparam int RIGHT_WR = 1;
    localparam int RIGHT_EX = 2;
    localparam int RIGHTS_W = 3;
endpackage

// File: rtl/xlat_rights_check.sv
// Decides whether an access kind is allowed by a permission field.
// Purely combinational. Access code 3 is handled as a load.
module xlat_rights_check
    import xlat_pkg::*;
(
    input  logic [1:0]          acc_i,
    input  logic [RIGHTS_W-1:0] rights_i,
    output logic                ok_o
);
    // Select the permission bit that matches the access kind.
    always_comb begin
        case (acc_i)
            ACC_STORE: ok_o = rights_i[RIGHT_WR];
            ACC_FETCH: ok_o = rights_i[RIGHT_EX];
            default:   ok_o = rights_i[RIGHT_RD];
        endcase
    end
endmodule

// File: rtl/xlat_victim_pick.sv
// Chooses the way a refill writes in a two-way set.
// Order of preference: a way already holding the page, then an invalid
// way (way 0 first), then the way whose recency flag is clear.
// Assumes at most one way matches the page being filled.
module xlat_victim_pick (
    input  logic [1:0] valid_i,
    input  logic [1:0] recent_i,
    input  logic [1:0] same_i,
    output logic       way_o
);
    // Walk the preference order to find the target way.
    always_comb begin
        if (same_i[0])          way_o = 1'b0;
        else if (same_i[1])     way_o = 1'b1;
        else if (!valid_i[0])   way_o = 1'b0;
        else if (!valid_i[1])   way_o = 1'b1;
        else if (!recent_i[0])  way_o = 1'b0;
        else if (!recent_i[1])  way_o = 1'b1;
        else                    way_o = 1'b0;
    end
endmodule

// File: rtl/xlat_way_store.sv
// Storage for one way of the buffer: a tag, page number and permissions
// per set, plus valid, recency and written flags. It has two read ports,
// one for the lookup index and one for the refill index.
// Flush has priority over every write. A refill beats a same-set
// written-flag update. Flags are reset; the payload is not.
module xlat_way_store
    import xlat_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int TAG_W = 43,
    parameter int PPN_W = 26,
    localparam int SETS = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    // lookup read port
    input  logic [IDX_W-1:0]    lk_idx_i,
    output logic                lk_valid_o,
    output logic                lk_recent_o,
    output logic                lk_dirty_o,
    output logic [TAG_W-1:0]    lk_tag_o,
    output logic [PPN_W-1:0]    lk_ppn_o,
    output logic [RIGHTS_W-1:0] lk_rights_o,
    // refill read port
    input  logic [IDX_W-1:0]    fl_idx_i,
    output logic                fl_valid_o,
    output logic                fl_recent_o,
    output logic [TAG_W-1:0]    fl_tag_o,
    // refill write
    input  logic                fl_we_i,
    input  logic [TAG_W-1:0]    fl_tag_i,
    input  logic [PPN_W-1:0]    fl_ppn_i,
    input  logic [RIGHTS_W-1:0] fl_rights_i,
    // recency write
    input  logic                rc_we_i,
    input  logic [IDX_W-1:0]    rc_idx_i,
    input  logic                rc_val_i,
    // written-flag set
    input  logic                dt_set_i,
    input  logic [IDX_W-1:0]    dt_idx_i
);
    logic [SETS-1:0]     valid_q;
    logic [SETS-1:0]     recent_q;
    logic [SETS-1:0]     dirty_q;
    logic [TAG_W-1:0]    tag_q    [SETS];
    logic [PPN_W-1:0]    ppn_q    [SETS];
    logic [RIGHTS_W-1:0] rights_q [SETS];

    // Read both ports combinationally.
    always_comb begin
        lk_valid_o  = valid_q[lk_idx_i];
        lk_recent_o = recent_q[lk_idx_i];
        lk_dirty_o  = dirty_q[lk_idx_i];
        lk_tag_o    = tag_q[lk_idx_i];
        lk_ppn_o    = ppn_q[lk_idx_i];
        lk_rights_o = rights_q[lk_idx_i];
        fl_valid_o  = valid_q[fl_idx_i];
        fl_recent_o = recent_q[fl_idx_i];
        fl_tag_o    = tag_q[fl_idx_i];
    end

    // Update the flags: reset, flush, refill, recency, written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            recent_q <= '0;
            dirty_q  <= '0;
        end else if (flush_i) begin
            valid_q  <= '0;
            recent_q <= '0;
        end else begin
            if (rc_we_i)
                recent_q[rc_idx_i] <= rc_val_i;
            if (dt_set_i && !(fl_we_i && fl_idx_i == dt_idx_i))
                dirty_q[dt_idx_i] <= 1'b1;
            if (fl_we_i) begin
                valid_q[fl_idx_i] <= 1'b1;
                dirty_q[fl_idx_i] <= 1'b0;
            end
        end
    end

    // Write the payload of a refilled entry.
    always_ff @(posedge clk) begin
        if (fl_we_i && !flush_i) begin
            tag_q[fl_idx_i]    <= fl_tag_i;
            ppn_q[fl_idx_i]    <= fl_ppn_i;
            rights_q[fl_idx_i] <= fl_rights_i;
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0));                                  // R10
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_i && !flush_i) |=> valid_q[$past(fl_idx_i)]);            // R7
endmodule

// File: rtl/xlat_buffer.sv
// Two-way set-associative page translation buffer.
// The lookup is decoded combinationally from the presented address, and
// its outcome, physical address and written flag are registered, giving
// one cycle of latency. Refill and flush take effect at the next edge.
// A refill has priority over a same-cycle lookup's recency update.
// Assumes the walker never asks to refill while a flush is pending.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int OFF_W = 14,
    parameter int IDX_W = 7,
    parameter int PA_W  = 40,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int TAG_W = VPN_W - IDX_W,
    localparam int PPN_W = PA_W - OFF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_i,
    input  logic                lk_valid_i,
    input  logic [VA_W-1:0]     lk_va_i,
    input  logic [1:0]          lk_acc_i,
    input  logic                fill_valid_i,
    input  logic [VPN_W-1:0]    fill_vpn_i,
    input  logic [PPN_W-1:0]    fill_ppn_i,
    input  logic [RIGHTS_W-1:0] fill_rights_i,
    output logic                lk_done_o,
    output logic                lk_hit_o,
    output logic                lk_miss_o,
    output logic                lk_fault_o,
    output logic [PA_W-1:0]     lk_pa_o,
    output logic                lk_dirty_o
);
    localparam int NWAYS = 2;

    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic [OFF_W-1:0] lk_off;

    logic [NWAYS-1:0]    rd_valid, rd_recent, rd_dirty;
    logic [TAG_W-1:0]    rd_tag    [NWAYS];
    logic [PPN_W-1:0]    rd_ppn    [NWAYS];
    logic [RIGHTS_W-1:0] rd_rights [NWAYS];
    logic [NWAYS-1:0]    fr_valid, fr_recent;
    logic [TAG_W-1:0]    fr_tag    [NWAYS];

    logic [NWAYS-1:0] match, fmatch, fill_we, dset;
    logic             any_match, sel_way, allowed, fill_go, victim;
    logic             hit_c, fault_c, miss_c, store_hit;
    logic             rc_we;
    logic [IDX_W-1:0] rc_idx;
    logic [NWAYS-1:0] rc_val;

    // Split the lookup address and the refill page number.
    always_comb begin
        lk_off = lk_va_i[OFF_W-1:0];
        lk_idx = lk_va_i[OFF_W +: IDX_W];
        lk_tag = lk_va_i[VA_W-1 -: TAG_W];
        fl_idx = fill_vpn_i[IDX_W-1:0];
        fl_tag = fill_vpn_i[VPN_W-1 -: TAG_W];
    end

    // One storage instance per way.
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        xlat_way_store #(
            .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)
        ) way_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush_i),
            .lk_idx_i    (lk_idx),
            .lk_valid_o  (rd_valid[w]),
            .lk_recent_o (rd_recent[w]),
            .lk_dirty_o  (rd_dirty[w]),
            .lk_tag_o    (rd_tag[w]),
            .lk_ppn_o    (rd_ppn[w]),
            .lk_rights_o (rd_rights[w]),
            .fl_idx_i    (fl_idx),
            .fl_valid_o  (fr_valid[w]),
            .fl_recent_o (fr_recent[w]),
            .fl_tag_o    (fr_tag[w]),
            .fl_we_i     (fill_we[w]),
            .fl_tag_i    (fl_tag),
            .fl_ppn_i    (fill_ppn_i),
            .fl_rights_i (fill_rights_i),
            .rc_we_i     (rc_we),
            .rc_idx_i    (rc_idx),
            .rc_val_i    (rc_val[w]),
            .dt_set_i    (dset[w]),
            .dt_idx_i    (lk_idx)
        );
        // Compare the stored tag against the lookup and the refill.
        always_comb begin
            match[w]  = rd_valid[w] && (rd_tag[w] == lk_tag);
            fmatch[w] = fr_valid[w] && (fr_tag[w] == fl_tag);
        end
    end

    // Pick the matching way for the lookup.
    always_comb begin
        any_match = |match;
        sel_way   = match[1];
    end

    xlat_rights_check rights_i (
        .acc_i    (lk_acc_i),
        .rights_i (rd_rights[sel_way]),
        .ok_o     (allowed)
    );

    xlat_victim_pick victim_i (
        .valid_i  (fr_valid),
        .recent_i (fr_recent),
        .same_i   (fmatch),
        .way_o    (victim)
    );

    // Classify the lookup and derive the update strobes.
    always_comb begin
        hit_c     = lk_valid_i && any_match && allowed;
        fault_c   = lk_valid_i && any_match && !allowed;
        miss_c    = lk_valid_i && !any_match;
        store_hit = hit_c && (lk_acc_i == ACC_STORE);
        fill_go   = fill_valid_i && !flush_i;
        for (int w = 0; w < NWAYS; w++) begin
            fill_we[w] = fill_go && (victim == w[0]);
            dset[w]    = store_hit && match[w] && !flush_i;
        end
    end

    // Recency update: a refill wins over a lookup match.
    always_comb begin
        rc_we  = 1'b0;
        rc_idx = lk_idx;
        rc_val = '0;
        if (fill_go) begin
            rc_we  = 1'b1;
            rc_idx = fl_idx;
            for (int w = 0; w < NWAYS; w++) rc_val[w] = (victim == w[0]);
        end else if (lk_valid_i && any_match) begin
            rc_we  = 1'b1;
            rc_idx = lk_idx;
            rc_val = match;
        end
    end

    // Register the lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_done_o  <= 1'b0;
            lk_hit_o   <= 1'b0;
            lk_miss_o  <= 1'b0;
            lk_fault_o <= 1'b0;
            lk_pa_o    <= '0;
            lk_dirty_o <= 1'b0;
        end else begin
            lk_done_o  <= lk_valid_i;
            lk_hit_o   <= hit_c;
            lk_miss_o  <= miss_c;
            lk_fault_o <= fault_c;
            lk_pa_o    <= hit_c ? {rd_ppn[sel_way], lk_off} : '0;
            lk_dirty_o <= hit_c && (rd_dirty[sel_way] || store_hit);
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done_o |-> $countones({lk_hit_o, lk_miss_o, lk_fault_o}) == 1); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_done_o |-> !(lk_hit_o || lk_miss_o || lk_fault_o));            // R2
    AST_PA_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit_o |-> (lk_pa_o == '0));                                    // R3
    AST_DIRTY_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dirty_o |-> lk_hit_o);                                          // R6
    AST_NO_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid[0] && rd_valid[1]) |-> (rd_tag[0] != rd_tag[1]));        // R9
    AST_RECENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_recent));                                              // R8
endmodule

// File: tb/xlat_buffer_tb_top.sv
module xlat_buffer_tb_top;
    localparam int VA_W  = 64;
    localparam int OFF_W = 14;
    localparam int IDX_W = 2;
    localparam int PA_W  = 40;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PPN_W = PA_W - OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 1'b0;
    logic lk_valid_i = 1'b0;
    logic [VA_W-1:0] lk_va_i = '0;
    logic [1:0] lk_acc_i = '0;
    logic fill_valid_i = 1'b0;
    logic [VPN_W-1:0] fill_vpn_i = '0;
    logic [PPN_W-1:0] fill_ppn_i = '0;
    logic [2:0] fill_rights_i = '0;
    logic lk_done_o, lk_hit_o, lk_miss_o, lk_fault_o, lk_dirty_o;
    logic [PA_W-1:0] lk_pa_o;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    xlat_buffer #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .lk_valid_i(lk_valid_i), .lk_va_i(lk_va_i), .lk_acc_i(lk_acc_i),
        .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i),
        .fill_ppn_i(fill_ppn_i), .fill_rights_i(fill_rights_i),
        .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o),
        .lk_fault_o(lk_fault_o), .lk_pa_o(lk_pa_o), .lk_dirty_o(lk_dirty_o)
    );

    function automatic logic [VA_W-1:0] mk(input logic [TAG_W-1:0] tag,
                                           input logic [IDX_W-1:0] idx,
                                           input logic [OFF_W-1:0] off);
        return {tag, idx, off};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // Present one lookup; outputs are sampled at the following falling edge.
    task automatic look(input logic [VA_W-1:0] va, input logic [1:0] acc);
        lk_valid_i = 1'b1; lk_va_i = va; lk_acc_i = acc;
        @(negedge clk);
        lk_valid_i = 1'b0;
    endtask

    task automatic fill(input logic [VA_W-1:0] va, input logic [PPN_W-1:0] ppn,
                        input logic [2:0] rights);
        fill_valid_i = 1'b1; fill_vpn_i = va[VA_W-1:OFF_W];
        fill_ppn_i = ppn; fill_rights_i = rights;
        @(negedge clk);
        fill_valid_i = 1'b0;
    endtask

    // Expect outcome: 0 miss, 1 hit, 2 fault.
    task automatic expect_look(input string req, input logic [VA_W-1:0] va,
                               input logic [1:0] acc, input int kind,
                               input logic [PPN_W-1:0] ppn, input logic dirty);
        look(va, acc);
        chk(req, "done", lk_done_o, 1);
        chk(req, "hit", lk_hit_o, kind == 1);
        chk(req, "miss", lk_miss_o, kind == 0);
        chk(req, "fault", lk_fault_o, kind == 2);
        chk(req, "pa", lk_pa_o, (kind == 1) ? {ppn, va[OFF_W-1:0]} : 40'h0);
        chk(req, "dirty", lk_dirty_o, (kind == 1) && dirty);
    endtask

    task automatic t_reset;  // R1
        chk("R1", "done", lk_done_o, 0);
        chk("R1", "hit", lk_hit_o, 0);
        chk("R1", "pa", lk_pa_o, 0);
        expect_look("R1", mk(48'h5, 2'd1, 14'h0), 2'd0, 0, 0, 0);
    endtask

    task automatic t_hit;  // R2 R3
        fill(mk(48'h5, 2'd1, 14'h0), 26'h123, 3'b011);
        expect_look("R3", mk(48'h5, 2'd1, 14'h2AB), 2'd0, 1, 26'h123, 0);
        @(negedge clk);
        chk("R2", "done idle", lk_done_o, 0);
        chk("R2", "hit idle", lk_hit_o, 0);
        expect_look("R2", mk(48'h5, 2'd1, 14'h3FFF), 2'd3, 1, 26'h123, 0);
    endtask

    task automatic t_split;  // R4
        expect_look("R4", mk(48'h5, 2'd2, 14'h10), 2'd0, 0, 0, 0);
        expect_look("R4", mk(48'h6, 2'd1, 14'h10), 2'd0, 0, 0, 0);
        expect_look("R4", mk(48'h8000_0000_0005, 2'd1, 14'h10), 2'd0, 0, 0, 0);
    endtask

    task automatic t_two_ways;  // R7
        fill(mk(48'h9, 2'd1, 0), 26'h456, 3'b011);
        expect_look("R7", mk(48'h5, 2'd1, 14'h1), 2'd0, 1, 26'h123, 0);
        expect_look("R7", mk(48'h9, 2'd1, 14'h2), 2'd0, 1, 26'h456, 0);
        fill(mk(48'hE, 2'd2, 0), 26'h0E0, 3'b001);
        fill(mk(48'hF, 2'd2, 0), 26'h0F0, 3'b001);
        expect_look("R7", mk(48'hE, 2'd2, 14'h3), 2'd0, 1, 26'h0E0, 0);
        expect_look("R7", mk(48'hF, 2'd2, 14'h4), 2'd0, 1, 26'h0F0, 0);
    endtask

    task automatic t_recency;  // R8
        look(mk(48'h5, 2'd1, 0), 2'd0);                 // A most recent
        fill(mk(48'hC, 2'd1, 0), 26'h789, 3'b011);      // evicts 9
        expect_look("R8", mk(48'h9, 2'd1, 14'h5), 2'd0, 0, 0, 0);
        expect_look("R8", mk(48'h5, 2'd1, 14'h6), 2'd0, 1, 26'h123, 0);
        expect_look("R8", mk(48'hC, 2'd1, 14'h7), 2'd0, 1, 26'h789, 0);
        fill(mk(48'hD, 2'd1, 0), 26'h0AA, 3'b011);      // evicts 5
        expect_look("R8", mk(48'h5, 2'd1, 14'h8), 2'd0, 0, 0, 0);
        expect_look("R8", mk(48'hD, 2'd1, 14'h9), 2'd0, 1, 26'h0AA, 0);
        expect_look("R8", mk(48'hC, 2'd1, 14'hA), 2'd0, 1, 26'h789, 0);
    endtask

    task automatic t_rights;  // R5
        fill(mk(48'h20, 2'd3, 0), 26'h200, 3'b100);
        expect_look("R5", mk(48'h20, 2'd3, 14'h1), 2'd2, 1, 26'h200, 0);
        expect_look("R5", mk(48'h20, 2'd3, 14'h1), 2'd0, 2, 0, 0);
        expect_look("R5", mk(48'h20, 2'd3, 14'h1), 2'd1, 2, 0, 0);
        expect_look("R5", mk(48'hC, 2'd1, 14'h1), 2'd2, 2, 0, 0);
    endtask

    task automatic t_dirty;  // R6
        expect_look("R6", mk(48'hC, 2'd1, 14'h11), 2'd0, 1, 26'h789, 0);
        expect_look("R6", mk(48'hC, 2'd1, 14'h12), 2'd1, 1, 26'h789, 1);
        expect_look("R6", mk(48'hC, 2'd1, 14'h13), 2'd0, 1, 26'h789, 1);
        fill(mk(48'h21, 2'd0, 0), 26'h210, 3'b001);
        expect_look("R6", mk(48'h21, 2'd0, 14'h1), 2'd1, 2, 0, 0);
        expect_look("R6", mk(48'h21, 2'd0, 14'h2), 2'd0, 1, 26'h210, 0);
    endtask

    task automatic t_same_page;  // R9 and R6 refill clears written flag
        fill(mk(48'hC, 2'd1, 0), 26'h777, 3'b011);
        expect_look("R9", mk(48'hC, 2'd1, 14'h21), 2'd0, 1, 26'h777, 0);
        expect_look("R9", mk(48'hD, 2'd1, 14'h22), 2'd0, 1, 26'h0AA, 0);
        fill(mk(48'h21, 2'd0, 0), 26'h211, 3'b011);
        expect_look("R9", mk(48'h21, 2'd0, 14'h3), 2'd1, 1, 26'h211, 1);
    endtask

    task automatic t_flush;  // R10
        flush_i = 1'b1;
        fill_valid_i = 1'b1; fill_vpn_i = mk(48'h30, 2'd0, 0) >> OFF_W;
        fill_ppn_i = 26'h300; fill_rights_i = 3'b111;
        @(negedge clk);
        flush_i = 1'b0; fill_valid_i = 1'b0;
        expect_look("R10", mk(48'hC, 2'd1, 0), 2'd0, 0, 0, 0);
        expect_look("R10", mk(48'hE, 2'd2, 0), 2'd0, 0, 0, 0);
        expect_look("R10", mk(48'h30, 2'd0, 0), 2'd0, 0, 0, 0);
        fill(mk(48'h31, 2'd0, 0), 26'h310, 3'b111);
        expect_look("R10", mk(48'h31, 2'd0, 14'h7), 2'd2, 1, 26'h310, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_hit();
                t_split();
                t_two_ways();
                t_recency();
                t_rights();
                t_dirty();
                t_same_page();
                t_flush();
            end
            begin
                repeat (20000) @(negedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule